// File: doc/BRIEF.md
# Edge Capture and External Count Unit

This block watches a small set of external capture inputs, sampling each one on every rising edge of the system clock. It compares each new sample with the sample taken one clock earlier and classifies the step as a rising edge, a falling edge, or no change. The same classification serves two purposes.

The first purpose is a capture register. When capture input 0 shows an enabled edge, the register loads the timer value that is present at that moment. It can also raise an interrupt pulse.

The second purpose is a counting source for the companion timer. In timer mode, the increment strobe fires on every clock. In counter mode, the strobe fires only on the chosen kind of edge on the chosen input, so an external signal paces the timer instead of the clock. The inputs are assumed to be synchronous to the clock already, and the timer itself lives outside this block. Because events come from two consecutive samples, an external signal can be counted reliably only up to half the clock rate.

Top module: `edge_cap_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `cap_val`, `cap_irq` and `cnt_inc` are cleared to 0, and the per-input sample history is cleared to 0.
- R2: With `cap_rise_en` = 1, a sample of 1 on `cap_in[0]` that follows a sample of 0 loads `tmr_val`, as presented at that clock edge, into `cap_val`. The new value is visible after that same edge.
- R3: With `cap_fall_en` = 1, a sample of 0 on `cap_in[0]` that follows a sample of 1 loads `tmr_val` into `cap_val` with the same timing as R2.
- R4: With both enables set, both edge kinds capture. With both enables clear, `cap_val` holds its value whatever `cap_in` does. `cap_in[1]` never causes a capture.
- R5: `cap_irq` is high for exactly the one cycle after a capture load when `cap_irq_en` = 1. It stays low when `cap_irq_en` = 0.
- R6: With `cnt_mode` = 0 (timer mode), `cnt_inc` is high in every cycle after the first clock edge out of reset, whatever the inputs do.
- R7: With `cnt_mode` = 1, 2 or 3, `cnt_inc` pulses for one cycle after each rising, falling or either edge, respectively, of the selected input. It is low otherwise.
- R8: `cnt_sel` = 0 selects `cap_in[0]` and `cnt_sel` = 1 selects `cap_in[1]`. The values 2 and 3 produce no count strobes in counter mode.
- R9: An input that is held high while reset is released is seen as a rising edge at the first clock edge after release. A level that is then held produces no further events.
- R10: An input that toggles on every clock (half the clock rate) yields one event per clock in both-edges mode and one capture per clock when both capture enables are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cap_in | input | NIN (2) | External capture inputs, already synchronous |
| tmr_val | input | TW (16) | Current timer counter value |
| cap_rise_en | input | 1 | Capture on a rising edge of input 0 |
| cap_fall_en | input | 1 | Capture on a falling edge of input 0 |
| cap_irq_en | input | 1 | Raise `cap_irq` on each capture load |
| cnt_mode | input | 2 | 0 timer, 1 rising, 2 falling, 3 both edges |
| cnt_sel | input | SEL_W (2) | Count input select; 0 and 1 valid, 2 and 3 idle |
| cap_val | output | TW (16) | Captured timer value |
| cap_irq | output | 1 | One-cycle capture interrupt pulse |
| cnt_inc | output | 1 | Timer increment strobe |

## Verification
The bench goes after the edge corners of this block.

One corner is a high level present at reset release, which a design that seeded its history from the input would miss. Another is a level held steady, where a level-sensitive design would keep counting or capturing on every cycle. A third is an input toggling on every clock, where a design that needed a settling cycle between edges would drop every other event.

The bench also checks the reserved select codes, which a design indexing past its inputs would turn into spurious strobes. It checks that captures come only from input 0, and that the interrupt stays quiet when it is disabled even though captures still load.

// File: rtl/ecu_pkg.sv
package ecu_pkg;

  typedef enum logic [1:0] {
    CM_TIMER = 2'd0,
    CM_RISE  = 2'd1,
    CM_FALL  = 2'd2,
    CM_BOTH  = 2'd3
  } cnt_mode_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

endpackage

// File: rtl/ecu_edge_det.sv
module ecu_edge_det #(
  parameter int NIN = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NIN-1:0] din,
  output logic [NIN-1:0] rise,
  output logic [NIN-1:0] fall
);

  // One history flop per input; the current sample is compared with it.
  for (genvar g = 0; g < NIN; g++) begin : g_ch
    logic hist_q;

    always_ff @(posedge clk) begin
      if (rst) hist_q <= 1'b0;
      else     hist_q <= din[g];
    end

    assign rise[g] =  din[g] & ~hist_q;
    assign fall[g] = ~din[g] &  hist_q;
  end

endmodule

// File: rtl/ecu_capture.sv
module ecu_capture #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise0,
  input  logic          fall0,
  input  logic          rise_en,
  input  logic          fall_en,
  input  logic          irq_en,
  input  logic [TW-1:0] tmr_val,
  output logic [TW-1:0] cap_val,
  output logic          cap_irq
);

  logic load;

  assign load = (rise_en & rise0) | (fall_en & fall0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_val <= '0;
      cap_irq <= 1'b0;
    end else begin
      if (load) cap_val <= tmr_val;
      cap_irq <= load & irq_en;
    end
  end

endmodule

// File: rtl/ecu_count_src.sv
module ecu_count_src #(
  parameter int NIN   = 2,
  parameter int SEL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NIN-1:0]    rise,
  input  logic [NIN-1:0]    fall,
  input  ecu_pkg::cnt_mode_e mode,
  input  logic [SEL_W-1:0]  sel,
  output logic              cnt_inc
);
  import ecu_pkg::*;

  edge_t sel_ev;
  logic  inc_d;

  // Codes at or above NIN leave sel_ev idle.
  always_comb begin
    sel_ev = '0;
    for (int i = 0; i < NIN; i++) begin
      if (sel == SEL_W'(i)) begin
        sel_ev.rise = rise[i];
        sel_ev.fall = fall[i];
      end
    end
  end

  always_comb begin
    unique case (mode)
      CM_TIMER: inc_d = 1'b1;
      CM_RISE:  inc_d = sel_ev.rise;
      CM_FALL:  inc_d = sel_ev.fall;
      default:  inc_d = sel_ev.rise | sel_ev.fall;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_inc <= 1'b0;
    else     cnt_inc <= inc_d;
  end

endmodule

// File: rtl/edge_cap_unit.sv
module edge_cap_unit #(
  parameter int TW    = 16,
  parameter int NIN   = 2,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NIN-1:0]   cap_in,
  input  logic [TW-1:0]    tmr_val,
  input  logic             cap_rise_en,
  input  logic             cap_fall_en,
  input  logic             cap_irq_en,
  input  logic [1:0]       cnt_mode,
  input  logic [SEL_W-1:0] cnt_sel,
  output logic [TW-1:0]    cap_val,
  output logic             cap_irq,
  output logic             cnt_inc
);

  logic [NIN-1:0] rise;
  logic [NIN-1:0] fall;

  ecu_edge_det #(.NIN(NIN)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .din  (cap_in),
    .rise (rise),
    .fall (fall)
  );

  ecu_capture #(.TW(TW)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .rise0   (rise[0]),
    .fall0   (fall[0]),
    .rise_en (cap_rise_en),
    .fall_en (cap_fall_en),
    .irq_en  (cap_irq_en),
    .tmr_val (tmr_val),
    .cap_val (cap_val),
    .cap_irq (cap_irq)
  );

  ecu_count_src #(.NIN(NIN), .SEL_W(SEL_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .rise    (rise),
    .fall    (fall),
    .mode    (ecu_pkg::cnt_mode_e'(cnt_mode)),
    .sel     (cnt_sel),
    .cnt_inc (cnt_inc)
  );

endmodule

// File: rtl/ecu_chk.sv
module ecu_chk #(
  parameter int TW    = 16,
  parameter int NIN   = 2,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [NIN-1:0]   cap_in,
  input logic [TW-1:0]    tmr_val,
  input logic             cap_rise_en,
  input logic             cap_fall_en,
  input logic             cap_irq_en,
  input logic [1:0]       cnt_mode,
  input logic [SEL_W-1:0] cnt_sel,
  input logic [TW-1:0]    cap_val,
  input logic             cap_irq,
  input logic             cnt_inc
);

  // Checker-side record of the previous samples, cleared like the design.
  logic [NIN-1:0] c_prev;
  always_ff @(posedge clk) begin
    if (rst) c_prev <= '0;
    else     c_prev <= cap_in;
  end

  p_rise_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (cap_rise_en && cap_in[0] && !c_prev[0]) |=> (cap_val == $past(tmr_val)));

  p_fall_capture_r3: assert property (@(posedge clk) disable iff (rst)
    (cap_fall_en && !cap_in[0] && c_prev[0]) |=> (cap_val == $past(tmr_val)));

  p_hold_when_off_r4: assert property (@(posedge clk) disable iff (rst)
    (!cap_rise_en && !cap_fall_en) |=> $stable(cap_val));

  p_irq_needs_enable_r5: assert property (@(posedge clk) disable iff (rst)
    cap_irq |-> $past(cap_irq_en));

  p_timer_every_clock_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt_mode == 2'd0) |=> cnt_inc);

  p_rise_count_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt_mode == 2'd1 && cnt_sel == '0 && cap_in[0] && !c_prev[0]) |=> cnt_inc);

  p_reserved_sel_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt_mode != 2'd0 && cnt_sel[SEL_W-1]) |=> !cnt_inc);

  p_second_input_count_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt_mode == 2'd3 && cnt_sel == SEL_W'(1) && (cap_in[NIN-1] != c_prev[NIN-1])) |=> cnt_inc);

endmodule

bind edge_cap_unit ecu_chk #(.TW(TW), .NIN(NIN), .SEL_W(SEL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cap_in      (cap_in),
  .tmr_val     (tmr_val),
  .cap_rise_en (cap_rise_en),
  .cap_fall_en (cap_fall_en),
  .cap_irq_en  (cap_irq_en),
  .cnt_mode    (cnt_mode),
  .cnt_sel     (cnt_sel),
  .cap_val     (cap_val),
  .cap_irq     (cap_irq),
  .cnt_inc     (cnt_inc)
);

// File: tb/edge_cap_unit_tb.sv
module edge_cap_unit_tb;
  localparam int TW    = 16;
  localparam int NIN   = 2;
  localparam int SEL_W = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst = 1'b1;
  logic [NIN-1:0]   cap_in = '0;
  logic [TW-1:0]    tmr_val = '0;
  logic             cap_rise_en = 1'b0;
  logic             cap_fall_en = 1'b0;
  logic             cap_irq_en = 1'b0;
  logic [1:0]       cnt_mode = 2'd0;
  logic [SEL_W-1:0] cnt_sel = '0;
  logic [TW-1:0]    cap_val;
  logic             cap_irq;
  logic             cnt_inc;

  edge_cap_unit #(.TW(TW), .NIN(NIN), .SEL_W(SEL_W)) u_dut (
    .clk(clk), .rst(rst), .cap_in(cap_in), .tmr_val(tmr_val),
    .cap_rise_en(cap_rise_en), .cap_fall_en(cap_fall_en), .cap_irq_en(cap_irq_en),
    .cnt_mode(cnt_mode), .cnt_sel(cnt_sel),
    .cap_val(cap_val), .cap_irq(cap_irq), .cnt_inc(cnt_inc)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";

  // Pending controls, applied by the driver at its drive edge.
  logic             c_rise = 0, c_fall = 0, c_irq = 0;
  logic [1:0]       c_mode = 0;
  logic [SEL_W-1:0] c_sel = 0;

  // Model state built from the requirements.
  logic [NIN-1:0] m_prev = '0;
  logic [TW-1:0]  m_val = '0;
  logic [TW-1:0]  tcnt = 16'h1000;

  logic [TW+1:0] qv[$];
  string         qr[$];

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [NIN-1:0] din);
    logic [NIN-1:0] r, f;
    logic ev, sr, sf, inc;
    @(negedge clk);
    rst = 1'b0;
    cap_in = din; tmr_val = tcnt;
    cap_rise_en = c_rise; cap_fall_en = c_fall; cap_irq_en = c_irq;
    cnt_mode = c_mode; cnt_sel = c_sel;
    r = din & ~m_prev;
    f = ~din & m_prev;
    ev = (c_rise & r[0]) | (c_fall & f[0]);
    if (ev) m_val = tcnt;
    sr = 1'b0; sf = 1'b0;
    if (c_sel == 0) begin sr = r[0]; sf = f[0]; end
    else if (c_sel == 1) begin sr = r[1]; sf = f[1]; end
    case (c_mode)
      2'd0:    inc = 1'b1;
      2'd1:    inc = sr;
      2'd2:    inc = sf;
      default: inc = sr | sf;
    endcase
    m_prev = din;
    qv.push_back({m_val, ev & c_irq, inc});
    qr.push_back(cur_req);
    tcnt = tcnt + 16'd7;
  endtask

  // Monitor: compares each result just after the edge that produced it.
  always @(posedge clk) begin
    #2;
    if (qv.size() > 0) begin
      logic [TW+1:0] e;
      string rq;
      e = qv.pop_front();
      rq = qr.pop_front();
      chk(rq, "cap_val", 32'(cap_val), 32'(e[TW+1:2]));
      chk(rq, "cap_irq", 32'(cap_irq), 32'(e[1]));
      chk(rq, "cnt_inc", 32'(cnt_inc), 32'(e[0]));
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] lfsr;
    // R1: reset clears outputs; input held high for the R9 case that follows.
    cap_in = 2'b11; cap_rise_en = 1; cap_irq_en = 1; cnt_mode = 2'd1;
    repeat (4) @(negedge clk);
    chk("R1", "cap_val", 32'(cap_val), 0);
    chk("R1", "cap_irq", 32'(cap_irq), 0);
    chk("R1", "cnt_inc", 32'(cnt_inc), 0);

    // R9: high level at release is a rising edge; held level gives nothing more.
    cur_req = "R9"; c_rise = 1; c_irq = 1; c_mode = 2'd1; c_sel = 0;
    step(2'b11); step(2'b11); step(2'b11);

    cur_req = "R2"; c_rise = 1; c_fall = 0; c_mode = 2'd0;
    step(2'b00); step(2'b01); step(2'b01); step(2'b00); step(2'b01);

    cur_req = "R3"; c_rise = 0; c_fall = 1;
    step(2'b00); step(2'b01); step(2'b00); step(2'b00);

    cur_req = "R4"; c_rise = 1; c_fall = 1;
    step(2'b01); step(2'b00); step(2'b01);
    c_rise = 0; c_fall = 0;
    step(2'b00); step(2'b01); step(2'b00);
    c_rise = 1; c_fall = 1;
    step(2'b10); step(2'b00); step(2'b10);

    cur_req = "R5"; c_irq = 0;
    step(2'b01); step(2'b00);
    c_irq = 1;
    step(2'b01); step(2'b01);

    cur_req = "R6"; c_mode = 2'd0;
    step(2'b10); step(2'b01); step(2'b11); step(2'b11);

    cur_req = "R7"; c_sel = 0;
    for (int m = 1; m < 4; m++) begin
      c_mode = 2'(m);
      step(2'b00); step(2'b01); step(2'b01); step(2'b00); step(2'b10);
    end

    cur_req = "R8"; c_mode = 2'd3; c_sel = 1;
    step(2'b00); step(2'b10); step(2'b11); step(2'b01); step(2'b00);
    for (int s = 2; s < 4; s++) begin
      c_sel = SEL_W'(s);
      step(2'b01); step(2'b10); step(2'b00); step(2'b11); step(2'b00);
    end

    cur_req = "R10"; c_mode = 2'd3; c_sel = 0; c_rise = 1; c_fall = 1; c_irq = 1;
    for (int k = 0; k < 12; k++) step({1'b0, k[0]});

    // Mixed patterns with changing controls.
    cur_req = "R7"; lfsr = 8'hA5;
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (k % 16 == 0) begin
        c_mode = lfsr[1:0]; c_sel = lfsr[3:2];
        c_rise = lfsr[4]; c_fall = lfsr[5]; c_irq = lfsr[6];
      end
      step(lfsr[7:6]);
    end

    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule